// File: doc/BRIEF.md
# Programmable Periodic Interrupt Rate Generator

This block turns a 32.768 kHz reference tick, delivered as a one-cycle enable on the system clock, into a periodic event at a power-of-two rate. A 4-bit rate code held in a writable register picks the rate. A larger code gives a lower frequency, and code zero switches the source off. A separate time-base field in the same register must hold the "32 kHz running" value, or the divider stays idle.

Each event sets a sticky periodic flag. The flag sets whether or not interrupts are enabled. A separate enable bit only decides whether the flag reaches the interrupt output. Software clears the flag through a clear strobe, which is normally pulsed by a status read. Writing the rate register restarts the internal prescaler, so the first period after a change is always a full one.

Top module: `periodic_rate_gen`

## Requirements
- R1: After reset, `per_flag`, `per_irq` and `en_o` are 0, `rate_o` is 0 and `base_o` is 0.
- R2: With rate code 0, no periodic event occurs and `per_flag` never sets, whatever the reference ticks do.
- R3: For codes 1 to 14 the period is 2^(code-1) reference ticks, from 2^15 Hz at code 1 down to 2^2 Hz at code 14. After a rate write, `per_flag` is first seen set 2^(code-1) ticks later, and then again every 2^(code-1) ticks.
- R4: Code 15 selects 2^0 Hz, a period of 2^15 reference ticks.
- R5: The divider runs only while the time-base field `base_o` equals 3'b010. Any other value holds the prescaler at zero, and no events occur.
- R6: `per_flag` sets on every event whether or not the enable is set. `per_irq` equals `per_flag` AND `en_o`.
- R7: Writing the enable (`en_wr`) changes only `en_o`. It leaves the rate code and the prescaler phase alone, so the next event arrives on schedule.
- R8: `per_flag` stays set until `flag_clr` is sampled high. It then reads 0 from the next clock edge, provided no event occurs in that cycle.
- R9: An event in the same cycle as `flag_clr` wins, and `per_flag` stays set.
- R10: Only clock cycles with `ref_tick` high advance the prescaler.
- R11: A rate-register write (`cfg_wr`) resets the prescaler to zero and suppresses any event in the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| cfg_wr | input | 1 | Write strobe for the rate register |
| cfg_rate | input | 4 | Rate code written on `cfg_wr` |
| cfg_base | input | 3 | Time-base field written on `cfg_wr` |
| en_wr | input | 1 | Write strobe for the periodic enable |
| en_data | input | 1 | Enable value written on `en_wr` |
| flag_clr | input | 1 | Clear strobe from a status read |
| per_flag | output | 1 | Sticky periodic event flag |
| per_irq | output | 1 | Flag gated by the enable |
| rate_o | output | 4 | Current rate code |
| base_o | output | 3 | Current time-base field |
| en_o | output | 1 | Current periodic enable |

## Verification
A wrong prescaler span or reset shows up at `per_flag` as an event that comes too early or too late: within 2^(code-1) ticks for short codes, and up to 2^15 ticks for code 15. For that reason the bench sweeps every code, measures the first and second period after each write exactly, and times the interval between events. A flag that is cleared by mistake, or one that fails to clear, shows on the edge after the clear strobe. A restart caused by an enable write shifts the next event and is caught at that event.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int PRESC_W  = 15;
  localparam int CODE_W   = 4;
  localparam int BASE_W   = 3;
  localparam logic [BASE_W-1:0] BASE_RUN = 3'b010;

  // number of low prescaler bits that must be all ones for an event
  function automatic int unsigned span_of(input logic [CODE_W-1:0] code);
    if (code == '0) return 0;
    else if (code == {CODE_W{1'b1}}) return PRESC_W;
    else return int'(code) - 1;
  endfunction

  function automatic logic [PRESC_W-1:0] mask_of(input int unsigned span);
    logic [PRESC_W-1:0] m;
    for (int i = 0; i < PRESC_W; i++) m[i] = (i < span);
    return m;
  endfunction
endpackage

// File: rtl/prg_cfg_regs.sv
module prg_cfg_regs #(
  parameter int CODE_W = 4,
  parameter int BASE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_rate,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              en_wr,
  input  logic              en_data,
  output logic [CODE_W-1:0] rate_q,
  output logic [BASE_W-1:0] base_q,
  output logic              en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= '0;
      base_q <= '0;
    end else if (cfg_wr) begin
      rate_q <= cfg_rate;
      base_q <= cfg_base;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_wr) en_q <= en_data;
  end
endmodule

// File: rtl/prg_prescaler.sv
module prg_prescaler #(
  parameter int PRESC_W = 15,
  parameter int CODE_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic               tick,
  input  logic [CODE_W-1:0]  code,
  output logic [PRESC_W-1:0] cnt,
  output logic               evt
);
  import prg_pkg::*;
  logic [PRESC_W-1:0] sel_mask;

  always_comb begin
    sel_mask = mask_of(span_of(code));
    evt = run && tick && !restart && ((cnt & sel_mask) == sel_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) cnt <= '0;
    else if (tick)                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/prg_flag.sv
module prg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (evt) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
  parameter int PRESC_W = prg_pkg::PRESC_W,
  parameter int CODE_W  = prg_pkg::CODE_W,
  parameter int BASE_W  = prg_pkg::BASE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_rate,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              en_wr,
  input  logic              en_data,
  input  logic              flag_clr,
  output logic              per_flag,
  output logic              per_irq,
  output logic [CODE_W-1:0] rate_o,
  output logic [BASE_W-1:0] base_o,
  output logic              en_o
);
  import prg_pkg::*;

  logic               div_run;
  logic               evt_w;
  logic [PRESC_W-1:0] presc_w;

  prg_cfg_regs #(.CODE_W(CODE_W), .BASE_W(BASE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rate(cfg_rate),
    .cfg_base(cfg_base), .en_wr(en_wr), .en_data(en_data),
    .rate_q(rate_o), .base_q(base_o), .en_q(en_o)
  );

  assign div_run = (base_o == BASE_RUN) && (rate_o != '0);

  prg_prescaler #(.PRESC_W(PRESC_W), .CODE_W(CODE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(div_run), .restart(cfg_wr),
    .tick(ref_tick), .code(rate_o), .cnt(presc_w), .evt(evt_w)
  );

  prg_flag u_flag (
    .clk(clk), .rst_n(rst_n), .evt(evt_w), .clr(flag_clr), .flag(per_flag)
  );

  assign per_irq = per_flag & en_o;
endmodule

// File: rtl/prg_checker.sv
module prg_checker #(
  parameter int PRESC_W = 15,
  parameter int CODE_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               evt,
  input logic               flag,
  input logic               clr,
  input logic               irq,
  input logic               en,
  input logic               cfg_wr,
  input logic               en_wr,
  input logic [CODE_W-1:0]  rate,
  input logic [PRESC_W-1:0] presc
);
  AST_CODE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0) |-> !evt); // R2
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && en)); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R8
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && clr && !evt) |=> !flag); // R8
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag); // R9
  AST_WR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (presc == '0)); // R11
  AST_EN_KEEPS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !cfg_wr) |=> $stable(rate)); // R7
endmodule

bind periodic_rate_gen prg_checker #(.PRESC_W(PRESC_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt_w), .flag(per_flag), .clr(flag_clr),
  .irq(per_irq), .en(en_o), .cfg_wr(cfg_wr), .en_wr(en_wr), .rate(rate_o),
  .presc(presc_w)
);

// File: tb/periodic_rate_gen_tb.sv
module periodic_rate_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_rate = '0;
  logic [2:0] cfg_base = '0;
  logic       en_wr = 1'b0;
  logic       en_data = 1'b0;
  logic       flag_clr = 1'b0;
  logic       per_flag, per_irq, en_o;
  logic [3:0] rate_o;
  logic [2:0] base_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  periodic_rate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_wr(cfg_wr),
    .cfg_rate(cfg_rate), .cfg_base(cfg_base), .en_wr(en_wr), .en_data(en_data),
    .flag_clr(flag_clr), .per_flag(per_flag), .per_irq(per_irq),
    .rate_o(rate_o), .base_o(base_o), .en_o(en_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected period in ticks, restated from R3/R4
  function automatic int period_of(input int code);
    if (code == 15) return 32768;
    return 1 << (code - 1);
  endfunction

  // write the rate register and clear the flag in the same cycle
  task automatic wr_cfg(input logic [3:0] code, input logic [2:0] base);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_rate = code; cfg_base = base; flag_clr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; flag_clr = 1'b0;
  endtask

  // count negedges until per_flag is seen, bounded
  task automatic wait_flag(input int limit, output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!per_flag && cnt < limit);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c, p;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(per_flag == 0 && per_irq == 0, "R1", per_flag, 0);
    chk(rate_o == 0 && base_o == 0 && en_o == 0, "R1", rate_o, 0);
    rst_n = 1'b1;
    ref_tick = 1'b1;

    // R2 code zero never fires
    wr_cfg(4'd0, 3'b010);
    repeat (200) @(negedge clk);
    chk(per_flag == 0, "R2", per_flag, 0);

    // R5 wrong time base holds the divider
    wr_cfg(4'd2, 3'b000);
    repeat (50) @(negedge clk);
    chk(per_flag == 0, "R5", per_flag, 0);
    wr_cfg(4'd2, 3'b110);
    repeat (50) @(negedge clk);
    chk(per_flag == 0, "R5", per_flag, 0);

    // R3/R4 sweep: first and second period, clear between (R8, R9 at code 1)
    for (int code = 1; code < 16; code++) begin
      p = period_of(code);
      wr_cfg(code[3:0], 3'b010);
      chk(rate_o == code[3:0], "R11", rate_o, code);
      wait_flag(40000, c);
      chk(c == p, (code == 15) ? "R4" : "R3", c, p);
      chk(per_irq == 0, "R6", per_irq, 0);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      if (p == 1) chk(per_flag == 1, "R9", per_flag, 1);
      else        chk(per_flag == 0, "R8", per_flag, 0);
      c = 1;
      while (!per_flag && c < 40000) begin
        @(negedge clk);
        c++;
      end
      chk(c == p, (code == 15) ? "R4" : "R3", c, p);
    end

    // R8 flag holds without clear
    repeat (10) @(negedge clk);
    chk(per_flag == 1, "R8", per_flag, 1);

    // R7 enable write mid-period keeps phase; R6 irq follows enable
    wr_cfg(4'd4, 3'b010);
    repeat (2) @(negedge clk);
    en_wr = 1'b1; en_data = 1'b1;
    @(negedge clk);
    en_wr = 1'b0;
    chk(en_o == 1 && rate_o == 4, "R7", rate_o, 4);
    chk(per_flag == 0, "R7", per_flag, 0);
    wait_flag(100, c);
    chk(c == 5, "R7", c + 3, 8);
    chk(per_irq == 1, "R6", per_irq, 1);

    // R11 rewrite mid-period restarts the count
    wr_cfg(4'd5, 3'b010);
    repeat (10) @(negedge clk);
    wr_cfg(4'd5, 3'b010);
    wait_flag(100, c);
    chk(c == 16, "R11", c, 16);

    // R10 only ticking cycles advance: code 2, tick on every third edge
    ref_tick = 1'b0;
    wr_cfg(4'd2, 3'b010);
    for (int j = 1; j <= 6; j++) begin
      ref_tick = (j % 3 == 0);
      @(negedge clk);
      if (j == 5) chk(per_flag == 0, "R10", per_flag, 0);
      if (j == 6) chk(per_flag == 1, "R10", per_flag, 1);
    end
    ref_tick = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule